// File: doc/BRIEF.md
# Level-Interrupt GPIO Port

A twelve-line general-purpose I/O block that sits on a simple 32-bit register bus. The bus has one-cycle read and write strobes, a byte address and a data word. Software sets the value each pad drives and whether the pad drives at all. It reads back the pad levels after a two-flop synchroniser, and it sets a 32-bit pin-mux word that leaves the block unchanged on its own port.

Any line can also request an interrupt on a level. Each line has one polarity bit. A line that sits at its active level sets its bit in a latched status register, and the enable mask does not affect this. Software clears a status bit by writing a one to it. If the source is still active, the bit sets again, so a level that software has not removed keeps asserting. One interrupt output carries the OR of every status bit whose enable bit is set.

The word index is taken from address bits [5:2], and the two low address bits are ignored. The eight words at indices 0 to 7 are defined. Every word above them reads as zero.

Top module: `gpio_lvl_top`

## Requirements
- R1: After reset, every register reads zero, pad_out and pad_oe are zero, mux_ctl is zero and irq is low.
- R2: A write to word 0 (drive data) or word 1 (drive enable) stores bits [11:0] and shows them on pad_out or pad_oe from the next cycle. These outputs and mux_ctl change only in the cycle after a bus write.
- R3: Reading word 2 returns pad_in in bits [11:0] delayed by two clock edges of synchronisation, with bits [31:12] zero.
- R4: Lines 0 to 7 take their polarity from word 4 and lines 8 to 11 from word 6. Line n uses bit 4*(n mod 8) of that word. A polarity bit of 0 makes the high level active and 1 makes the low level active.
- R5: In the cycle after a line's synchronised level is active, its bit in word 3 (status) is set, whatever its enable bit holds.
- R6: Writing word 3 clears each status bit written with 1 whose line is not active, and it leaves bits written with 0 unchanged. A status bit never sets unless its line was active in the cycle before.
- R7: If a status bit is cleared while its line is still active, the set wins and the bit stays 1.
- R8: irq is high exactly when some line has both its status bit and its bit in word 5 (enable, 1 = unmasked) set.
- R9: A write to word 7 stores all 32 bits. They appear on mux_ctl from the next cycle, and reading word 7 returns them.
- R10: Reads of word indices 8 to 15 return zero, and so do reads of unused bits of words 0, 1, 2, 3 and 5. bus_rdata is zero whenever bus_rd is low.
- R11: Reading word 4 or word 6 returns the stored polarity bits at their positions and zero in all other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational while bus_rd is high |
| pad_in | input | 12 | Asynchronous pad levels |
| pad_out | output | 12 | Value driven onto each pad |
| pad_oe | output | 12 | Per-pad drive enable (0 = tri-state) |
| mux_ctl | output | 32 | Pin-mux control word |
| irq | output | 1 | Shared level interrupt |

## Verification
The checker module runs on every cycle. It checks that an active level from the previous cycle is present in status, that no status bit appears without such a level, that the pad and mux outputs hold still when there was no write, and that irq stays low when the enable mask or the status is empty. The bench scenarios are the only place to see the bit positions of the polarity fields, the two-cycle input latency, the zero read-back of undefined words, and a clear that loses against a level still present. A model driven by random bus traffic and random pad changes tracks all of these.

// File: rtl/gpio_lvl_pkg.sv
package gpio_lvl_pkg;
  localparam int WORDS_DEFINED = 8;

  typedef enum logic [2:0] {
    W_DOUT = 3'd0,
    W_DOE  = 3'd1,
    W_DIN  = 3'd2,
    W_STAT = 3'd3,
    W_TYP0 = 3'd4,
    W_IEN  = 3'd5,
    W_TYP1 = 3'd6,
    W_MUX  = 3'd7
  } gpio_word_e;
endpackage

// File: rtl/gpio_lvl_rstsync.sv
module gpio_lvl_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/gpio_lvl_sync2.sv
module gpio_lvl_sync2 #(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic meta_q, hold_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        hold_q <= 1'b0;
      end else begin
        meta_q <= async_in[i];
        hold_q <= meta_q;
      end
    end
    assign sync_out[i] = hold_q;
  end
endmodule

// File: rtl/gpio_lvl_irqcore.sv
module gpio_lvl_irqcore #(
  parameter int NLINES = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] lvl,
  input  logic [NLINES-1:0] pol,
  input  logic              clr_we,
  input  logic [NLINES-1:0] clr_mask,
  input  logic [NLINES-1:0] ien,
  output logic [NLINES-1:0] status,
  output logic              irq
);
  logic [NLINES-1:0] active;
  logic [NLINES-1:0] stat_d, stat_q;

  always_comb begin
    active = lvl ^ pol;
    stat_d = stat_q;
    if (clr_we) stat_d = stat_d & ~clr_mask;
    stat_d = stat_d | active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign status = stat_q;
  assign irq    = |(stat_q & ien);
endmodule

// File: rtl/gpio_lvl_top.sv
module gpio_lvl_top
  import gpio_lvl_pkg::*;
#(
  parameter int NLINES         = 12,
  parameter int DW             = 32,
  parameter int AW             = 6,
  parameter int TSTRIDE        = 4,
  parameter int LINES_PER_TYPE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NLINES-1:0] pad_in,
  output logic [NLINES-1:0] pad_out,
  output logic [NLINES-1:0] pad_oe,
  output logic [DW-1:0]     mux_ctl,
  output logic              irq
);
  localparam int WIDX_W = AW - 2;

  logic              rst_n_q;
  logic [WIDX_W-1:0] widx;
  logic              in_map;
  logic [WORDS_DEFINED-1:0] wsel;
  logic              unused_addr_lo;

  logic [NLINES-1:0] dout_q, dout_d;
  logic [NLINES-1:0] doe_q, doe_d;
  logic [NLINES-1:0] pol_q, pol_d;
  logic [NLINES-1:0] ien_q, ien_d;
  logic [DW-1:0]     mux_q, mux_d;
  logic              pol_en;
  logic [NLINES-1:0] sync_lvl;
  logic [NLINES-1:0] stat_q;
  logic [1:0][DW-1:0] typ_rd;
  logic [DW-1:0]     rd_mux;

  gpio_lvl_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_q)
  );

  gpio_lvl_sync2 #(.WIDTH(NLINES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n_q),
    .async_in (pad_in),
    .sync_out (sync_lvl)
  );

  assign widx           = bus_addr[AW-1:2];
  assign in_map         = (widx >> 3) == '0;
  assign unused_addr_lo = ^bus_addr[1:0];

  always_comb begin
    wsel = '0;
    if (bus_wr && in_map) wsel[widx[2:0]] = 1'b1;
  end

  always_comb begin
    dout_d = bus_wdata[NLINES-1:0];
    doe_d  = bus_wdata[NLINES-1:0];
    ien_d  = bus_wdata[NLINES-1:0];
    mux_d  = bus_wdata;
    pol_en = wsel[W_TYP0] | wsel[W_TYP1];
    pol_d  = pol_q;
    for (int i = 0; i < NLINES; i++) begin
      if ((i / LINES_PER_TYPE) == 0) begin
        if (wsel[W_TYP0]) pol_d[i] = bus_wdata[TSTRIDE*(i % LINES_PER_TYPE)];
      end else begin
        if (wsel[W_TYP1]) pol_d[i] = bus_wdata[TSTRIDE*(i % LINES_PER_TYPE)];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_q) begin
    if (!rst_n_q) begin
      dout_q <= '0;
      doe_q  <= '0;
      pol_q  <= '0;
      ien_q  <= '0;
      mux_q  <= '0;
    end else begin
      if (wsel[W_DOUT]) dout_q <= dout_d;
      if (wsel[W_DOE])  doe_q  <= doe_d;
      if (pol_en)       pol_q  <= pol_d;
      if (wsel[W_IEN])  ien_q  <= ien_d;
      if (wsel[W_MUX])  mux_q  <= mux_d;
    end
  end

  gpio_lvl_irqcore #(.NLINES(NLINES)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n_q),
    .lvl      (sync_lvl),
    .pol      (pol_q),
    .clr_we   (wsel[W_STAT]),
    .clr_mask (bus_wdata[NLINES-1:0]),
    .ien      (ien_q),
    .status   (stat_q),
    .irq      (irq)
  );

  always_comb begin
    typ_rd = '0;
    for (int i = 0; i < NLINES; i++) begin
      typ_rd[i / LINES_PER_TYPE][TSTRIDE*(i % LINES_PER_TYPE)] = pol_q[i];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (bus_rd && in_map) begin
      case (gpio_word_e'(widx[2:0]))
        W_DOUT:  rd_mux = DW'(dout_q);
        W_DOE:   rd_mux = DW'(doe_q);
        W_DIN:   rd_mux = DW'(sync_lvl);
        W_STAT:  rd_mux = DW'(stat_q);
        W_TYP0:  rd_mux = typ_rd[0];
        W_IEN:   rd_mux = DW'(ien_q);
        W_TYP1:  rd_mux = typ_rd[1];
        W_MUX:   rd_mux = mux_q;
        default: rd_mux = '0;
      endcase
    end
  end

  assign bus_rdata = rd_mux;
  assign pad_out   = dout_q;
  assign pad_oe    = doe_q;
  assign mux_ctl   = mux_q;
endmodule

// File: rtl/gpio_lvl_chk.sv
module gpio_lvl_chk #(
  parameter int NLINES = 12,
  parameter int DW     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [NLINES-1:0] pad_out,
  input logic [NLINES-1:0] pad_oe,
  input logic [DW-1:0]     mux_ctl,
  input logic              irq,
  input logic [NLINES-1:0] sync_lvl,
  input logic [NLINES-1:0] pol,
  input logic [NLINES-1:0] status,
  input logic [NLINES-1:0] ien
);
  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R5
  status_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((status & ($past(sync_lvl) ^ $past(pol))) == ($past(sync_lvl) ^ $past(pol))));

  // R6
  status_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((status & ~$past(status) & ~($past(sync_lvl) ^ $past(pol))) == '0));

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(bus_wr)) |-> ($stable(pad_out) && $stable(pad_oe) && $stable(mux_ctl)));

  // R8
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq);

  // R8
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |-> !irq);
endmodule

bind gpio_lvl_top gpio_lvl_chk #(.NLINES(NLINES), .DW(DW)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_wr   (bus_wr),
  .pad_out  (pad_out),
  .pad_oe   (pad_oe),
  .mux_ctl  (mux_ctl),
  .irq      (irq),
  .sync_lvl (sync_lvl),
  .pol      (pol_q),
  .status   (stat_q),
  .ien      (ien_q)
);

// File: tb/gpio_lvl_tb.sv
module gpio_lvl_top_tb_top;
  localparam int N = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] pad_in = '0;
  logic [N-1:0] pad_out, pad_oe;
  logic [31:0] mux_ctl;
  logic        irq;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit          done = 1'b0;

  logic [N-1:0] m_dout = '0, m_doe = '0, m_pol = '0, m_ien = '0, m_stat = '0;
  logic [N-1:0] m_s1 = '0, m_s2 = '0;
  logic [31:0]  m_mux = '0;
  logic [31:0]  last_rd;

  always #2 clk = ~clk;

  gpio_lvl_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .mux_ctl(mux_ctl), .irq(irq)
  );

  function automatic logic [31:0] spread(input int base);
    logic [31:0] v = '0;
    for (int i = base; i < N && i < base + 8; i++) v[4*(i-base)] = m_pol[i];
    return v;
  endfunction

  function automatic logic [31:0] exp_read(input logic [5:0] a);
    case (a[5:2])
      4'd0: return 32'(m_dout);
      4'd1: return 32'(m_doe);
      4'd2: return 32'(m_s2);
      4'd3: return 32'(m_stat);
      4'd4: return spread(0);
      4'd5: return 32'(m_ien);
      4'd6: return spread(8);
      4'd7: return m_mux;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string req_of(input logic [5:0] a);
    case (a[5:2])
      4'd0, 4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R5/R6";
      4'd4, 4'd6: return "R11";
      4'd5: return "R8";
      4'd7: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycle(input bit wr, input bit rd, input logic [5:0] a,
                       input logic [31:0] wd, input logic [N-1:0] pads);
    logic [N-1:0] act;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd; pad_in = pads;
    #1;
    last_rd = bus_rdata;
    check("R2", 32'(pad_out), 32'(m_dout));
    check("R2", 32'(pad_oe), 32'(m_doe));
    check("R9", mux_ctl, m_mux);
    check("R8", 32'(irq), 32'(|(m_stat & m_ien)));
    if (rd) check(req_of(a), bus_rdata, exp_read(a));
    else    check("R10", bus_rdata, 32'h0);
    @(posedge clk);
    act = m_s2 ^ m_pol;
    if (wr && a[5:2] == 4'd3) m_stat = m_stat & ~wd[N-1:0];
    m_stat = m_stat | act;
    m_s2 = m_s1; m_s1 = pads;
    if (wr) begin
      case (a[5:2])
        4'd0: m_dout = wd[N-1:0];
        4'd1: m_doe = wd[N-1:0];
        4'd4: for (int i = 0; i < 8; i++) m_pol[i] = wd[4*i];
        4'd5: m_ien = wd[N-1:0];
        4'd6: for (int i = 8; i < N; i++) m_pol[i] = wd[4*(i-8)];
        4'd7: m_mux = wd;
        default: ;
      endcase
    end
  endtask

  task automatic idle(input int n, input logic [N-1:0] pads);
    for (int k = 0; k < n; k++) cycle(1'b0, 1'b0, 6'h0, 32'h0, pads);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] pads;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state on every word
    for (int w = 0; w < 8; w++) begin
      cycle(1'b0, 1'b1, 6'(w*4), 32'h0, '0);
      check("R1", last_rd, 32'h0);
    end
    check("R1", {pad_out, pad_oe, 7'h0, irq}, 32'h0);

    // R4 / R5: line 9 active-low via bit 4 of word 6, enable masked
    cycle(1'b1, 1'b0, 6'h18, 32'h0000_0010, '0);
    idle(2, '0);
    cycle(1'b0, 1'b1, 6'h0C, 32'h0, '0);
    check("R4", last_rd, 32'h0000_0200);
    check("R5", 32'(irq), 32'h0);
    cycle(1'b1, 1'b0, 6'h18, 32'h0, '0);
    cycle(1'b1, 1'b0, 6'h0C, 32'hFFF, '0);
    cycle(1'b0, 1'b1, 6'h0C, 32'h0, '0);
    check("R6", last_rd, 32'h0);

    // R7: clear while line 3 is held high, set must win
    pads = 12'h008;
    idle(4, pads);
    cycle(1'b1, 1'b0, 6'h14, 32'h008, pads);
    cycle(1'b1, 1'b0, 6'h0C, 32'hFFF, pads);
    cycle(1'b0, 1'b1, 6'h0C, 32'h0, pads);
    check("R7", last_rd, 32'h008);
    check("R8", 32'(irq), 32'h1);
    cycle(1'b0, 1'b1, 6'h08, 32'h0, pads);
    check("R3", last_rd, 32'h008);
    idle(3, '0);
    cycle(1'b1, 1'b0, 6'h0C, 32'h000, '0);
    cycle(1'b0, 1'b1, 6'h0C, 32'h0, '0);
    check("R6", last_rd, 32'h008);
    cycle(1'b1, 1'b0, 6'h0C, 32'h008, '0);
    cycle(1'b0, 1'b1, 6'h0C, 32'h0, '0);
    check("R6", last_rd, 32'h0);

    // R9 / R10 directed
    cycle(1'b1, 1'b0, 6'h1C, 32'hA5C3_0F96, '0);
    cycle(1'b0, 1'b1, 6'h1F, 32'h0, '0);
    check("R9", last_rd, 32'hA5C3_0F96);
    cycle(1'b0, 1'b1, 6'h24, 32'h0, '0);
    check("R10", last_rd, 32'h0);

    // random traffic against the model
    pads = '0;
    for (int k = 0; k < 6000; k++) begin
      bit wr, rd;
      logic [5:0] a;
      logic [31:0] wd;
      wr = ($urandom % 4) == 0;
      rd = ($urandom % 2) == 0;
      a  = 6'($urandom);
      if (($urandom % 4) != 0) a[5] = 1'b0;
      wd = $urandom;
      if (($urandom % 8) == 0) pads = N'($urandom);
      cycle(wr, rd, a, wd, pads);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule